// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block walks a framebuffer in memory once per frame and turns it into a stream of burst read requests for the display pipeline. Software programs where the image starts, how many bytes of pixels each line holds, the distance in bytes from one line's start to the next, and how many lines there are. On each frame-start pulse the block takes a snapshot of those settings and issues bursts line by line until the whole image is covered.

Requests leave on a request/grant address channel. Each request carries a start address and a beat count. A response pulse from the memory side marks the completion of one earlier request. A programmable cap limits how many requests may be in flight at once. A one-cycle end-of-frame pulse follows acceptance of the last burst of the last line. The read data path and the pixel FIFO belong to neighbouring blocks.

Top module: `fb_scan_addrgen`

## Requirements
- R1: While reset is asserted and after it is released, with no frame started, rd_req and frame_end stay low.
- R2: Register select codes are 0 base address, 1 line length in bytes, 2 line pitch in bytes, 3 line count minus one, 4 bus options. Line k of a frame starts at base + k * pitch, and its first request carries that address.
- R3: A line needs ceil(length / 8) beats of 8 bytes, and a length of zero counts as one beat. Within a line, requests are contiguous, each of the selected burst size, and the last one is shortened to the remaining beats.
- R4: Bus options bits [1:0] choose the burst size: 0 for 1 beat, 1 for 4, 2 for 8 and 3 for 16. Bits [11:8] hold the outstanding-request limit minus one.
- R5: rd_req is never raised while the number of accepted requests without a matching rd_done equals the limit. Each rd_done pulse frees one slot.
- R6: While rd_req is high and rd_gnt is low, rd_req stays high and rd_addr and rd_beats hold their values.
- R7: All settings are captured on the frame-start pulse. Register writes made during a frame do not alter that frame and take effect from the next frame start.
- R8: The line-count register stores lines minus one. A written value above 4095 is stored as 4095, which gives 4096 lines.
- R9: frame_end is high for exactly one cycle, the cycle after the final request of the frame is accepted, and once per frame.
- R10: A frame-start pulse that arrives while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Start-of-frame pulse |
| rd_req | output | 1 | Read request valid |
| rd_addr | output | AW | Byte address of the burst |
| rd_beats | output | 5 | Beats in the burst (1 to 16) |
| rd_gnt | input | 1 | Request accepted in this cycle |
| rd_done | input | 1 | One earlier request has completed |
| frame_end | output | 1 | End-of-frame pulse |

## Verification
A wrong line counter or line-start register shows up on rd_addr at the first request of the next line, and a wrong beat counter shows up on rd_beats at the last burst of the current line. The per-cycle reference comparison therefore catches either fault within one line of the error. A skewed outstanding counter shows up either as a request raised while the cap is reached or as a stall with no request pending. The first case is caught in the cycle it happens. The second surfaces as an rd_req mismatch in the cycle after the next rd_done. A lost or doubled end-of-frame pulse is visible one cycle after the final grant.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic {SQ_IDLE, SQ_RUN} sq_state_e;

  localparam logic [2:0] SEL_BASE  = 3'd0;
  localparam logic [2:0] SEL_LEN   = 3'd1;
  localparam logic [2:0] SEL_PITCH = 3'd2;
  localparam logic [2:0] SEL_LINES = 3'd3;
  localparam logic [2:0] SEL_BUS   = 3'd4;

  // burst size code to beat count
  function automatic logic [4:0] burst_beats(input logic [1:0] code);
    case (code)
      2'd0:    burst_beats = 5'd1;
      2'd1:    burst_beats = 5'd4;
      2'd2:    burst_beats = 5'd8;
      default: burst_beats = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/fbs_regs.sv
module fbs_regs
  import fbs_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LEN_W  = 16,
  parameter int LINE_W = 12,
  parameter int LIMC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [31:0]       wd,
  output logic [AW-1:0]     base_o,
  output logic [AW-1:0]     pitch_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [LINE_W-1:0] lines_o,
  output logic [1:0]        bcode_o,
  output logic [LIMC_W-1:0] limc_o
);

  logic              base_en, pitch_en, len_en, lines_en, bus_en;
  logic [LINE_W-1:0] lines_d;

  always_comb begin
    base_en  = we && (sel == SEL_BASE);
    len_en   = we && (sel == SEL_LEN);
    pitch_en = we && (sel == SEL_PITCH);
    lines_en = we && (sel == SEL_LINES);
    bus_en   = we && (sel == SEL_BUS);
    lines_d  = (|wd[31:LINE_W]) ? {LINE_W{1'b1}} : wd[LINE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_o  <= '0;
      pitch_o <= '0;
      len_o   <= '0;
      lines_o <= '0;
      bcode_o <= '0;
      limc_o  <= '0;
    end else begin
      if (base_en)  base_o  <= wd[AW-1:0];
      if (pitch_en) pitch_o <= wd[AW-1:0];
      if (len_en)   len_o   <= wd[LEN_W-1:0];
      if (lines_en) lines_o <= lines_d;
      if (bus_en) begin
        bcode_o <= wd[1:0];
        limc_o  <= wd[8 +: LIMC_W];
      end
    end
  end

endmodule

// File: rtl/fbs_credit.sv
module fbs_credit #(
  parameter int OUT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic [OUT_W-1:0] lim,
  output logic             room
);

  logic [OUT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    case ({inc, dec})
      2'b10:   cnt_d = cnt_q + OUT_W'(1);
      2'b01:   cnt_d = cnt_q - OUT_W'(1);
      default: cnt_d = cnt_q;
    endcase
    room = cnt_q < lim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fbs_seq.sv
module fbs_seq
  import fbs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_W     = 12,
  parameter int LIMC_W     = 4,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [AW-1:0]     cfg_base,
  input  logic [AW-1:0]     cfg_pitch,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic [1:0]        cfg_bcode,
  input  logic [LIMC_W-1:0] cfg_limc,
  input  logic              room,
  input  logic              gnt,
  output logic              req,
  output logic [AW-1:0]     addr,
  output logic [4:0]        beats,
  output logic              accept,
  output logic              frame_end,
  output logic [LIMC_W:0]   lim,
  output logic [4:0]        bmax
);

  localparam int BB_SH  = $clog2(BEAT_BYTES);
  localparam int BEAT_W = LEN_W - BB_SH + 1;

  sq_state_e         st_q, st_d;
  logic [LINE_W-1:0] line_q, line_d, nlines_q, nlines_d;
  logic [AW-1:0]     lstart_q, lstart_d, cur_q, cur_d, pitch_q, pitch_d;
  logic [BEAT_W-1:0] left_q, left_d, lbeats_q, lbeats_d;
  logic [4:0]        bmax_q, bmax_d;
  logic [LIMC_W:0]   lim_q, lim_d;
  logic              eof_q, eof_d;

  logic [LEN_W:0]    len_rnd;
  logic [BEAT_W-1:0] lb_raw, lb;
  logic              last_burst;

  // beats per line, rounded up, never zero
  always_comb begin
    len_rnd = {1'b0, cfg_len} + (LEN_W+1)'(BEAT_BYTES - 1);
    lb_raw  = BEAT_W'(len_rnd >> BB_SH);
    lb      = (lb_raw == '0) ? BEAT_W'(1) : lb_raw;
  end

  always_comb begin
    last_burst = left_q <= BEAT_W'(bmax_q);
    beats      = last_burst ? 5'(left_q) : bmax_q;
    req        = (st_q == SQ_RUN) && room;
    accept     = req && gnt;
    addr       = cur_q;
    frame_end  = eof_q;
    lim        = lim_q;
    bmax       = bmax_q;
  end

  always_comb begin
    st_d     = st_q;
    line_d   = line_q;
    nlines_d = nlines_q;
    lstart_d = lstart_q;
    cur_d    = cur_q;
    pitch_d  = pitch_q;
    left_d   = left_q;
    lbeats_d = lbeats_q;
    bmax_d   = bmax_q;
    lim_d    = lim_q;
    eof_d    = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (frame_start) begin
          st_d     = SQ_RUN;
          lstart_d = cfg_base;
          cur_d    = cfg_base;
          pitch_d  = cfg_pitch;
          lbeats_d = lb;
          left_d   = lb;
          nlines_d = cfg_lines;
          line_d   = '0;
          bmax_d   = burst_beats(cfg_bcode);
          lim_d    = {1'b0, cfg_limc} + (LIMC_W+1)'(1);
        end
      end
      SQ_RUN: begin
        if (accept) begin
          if (last_burst) begin
            if (line_q == nlines_q) begin
              st_d  = SQ_IDLE;
              eof_d = 1'b1;
            end else begin
              line_d   = line_q + LINE_W'(1);
              lstart_d = lstart_q + pitch_q;
              cur_d    = lstart_q + pitch_q;
              left_d   = lbeats_q;
            end
          end else begin
            cur_d  = cur_q + (AW'(beats) << BB_SH);
            left_d = left_q - BEAT_W'(beats);
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      line_q   <= '0;
      nlines_q <= '0;
      lstart_q <= '0;
      cur_q    <= '0;
      pitch_q  <= '0;
      left_q   <= '0;
      lbeats_q <= '0;
      bmax_q   <= 5'd1;
      lim_q    <= '0;
      eof_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      line_q   <= line_d;
      nlines_q <= nlines_d;
      lstart_q <= lstart_d;
      cur_q    <= cur_d;
      pitch_q  <= pitch_d;
      left_q   <= left_d;
      lbeats_q <= lbeats_d;
      bmax_q   <= bmax_d;
      lim_q    <= lim_d;
      eof_q    <= eof_d;
    end
  end

endmodule

// File: rtl/fb_scan_addrgen.sv
module fb_scan_addrgen
  import fbs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_W     = 12,
  parameter int LIMC_W     = 4,
  parameter int BEAT_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          frame_start,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic [4:0]    rd_beats,
  input  logic          rd_gnt,
  input  logic          rd_done,
  output logic          frame_end
);

  localparam int OUT_W = LIMC_W + 1;

  logic [AW-1:0]     base_w, pitch_w;
  logic [LEN_W-1:0]  len_w;
  logic [LINE_W-1:0] lines_w;
  logic [1:0]        bcode_w;
  logic [LIMC_W-1:0] limc_w;
  logic [OUT_W-1:0]  lim_w;
  logic [4:0]        bmax_w;
  logic              room_w, acc_w;

  fbs_regs #(.AW(AW), .LEN_W(LEN_W), .LINE_W(LINE_W), .LIMC_W(LIMC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wd(cfg_wdata),
    .base_o(base_w), .pitch_o(pitch_w), .len_o(len_w), .lines_o(lines_w),
    .bcode_o(bcode_w), .limc_o(limc_w)
  );

  fbs_credit #(.OUT_W(OUT_W)) u_credit (
    .clk(clk), .rst_n(rst_n), .inc(acc_w), .dec(rd_done), .lim(lim_w), .room(room_w)
  );

  fbs_seq #(.AW(AW), .LEN_W(LEN_W), .LINE_W(LINE_W), .LIMC_W(LIMC_W),
            .BEAT_BYTES(BEAT_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_base(base_w), .cfg_pitch(pitch_w), .cfg_len(len_w), .cfg_lines(lines_w),
    .cfg_bcode(bcode_w), .cfg_limc(limc_w), .room(room_w), .gnt(rd_gnt),
    .req(rd_req), .addr(rd_addr), .beats(rd_beats), .accept(acc_w),
    .frame_end(frame_end), .lim(lim_w), .bmax(bmax_w)
  );

endmodule

// File: rtl/fbs_chk.sv
module fbs_chk #(
  parameter int AW    = 32,
  parameter int OUT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic             rd_gnt,
  input logic             rd_done,
  input logic [AW-1:0]    rd_addr,
  input logic [4:0]       rd_beats,
  input logic             frame_end,
  input logic [OUT_W-1:0] lim,
  input logic [4:0]       bmax
);

  // in-flight count kept from port activity only
  logic [OUT_W:0] oc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oc_q <= '0;
    else        oc_q <= oc_q + (OUT_W+1)'(rd_req && rd_gnt) - (OUT_W+1)'(rd_done);
  end

  // R5
  out_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (oc_q < {1'b0, lim}));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr) && $stable(rd_beats)));

  // R3
  burst_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ((rd_beats != 5'd0) && (rd_beats <= bmax)));

  // R9
  eof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  // R9
  eof_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> $past(rd_req && rd_gnt));

endmodule

bind fb_scan_addrgen fbs_chk #(.AW(AW), .OUT_W(OUT_W)) u_fbs_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_done(rd_done),
  .rd_addr(rd_addr), .rd_beats(rd_beats), .frame_end(frame_end),
  .lim(lim_w), .bmax(bmax_w)
);

// File: tb/test_fb_scan_addrgen.sv
`timescale 1ns/1ps
module test_fb_scan_addrgen;

  localparam int BB = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        frame_start;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic [4:0]  rd_beats;
  logic        rd_gnt;
  logic        rd_done;
  logic        frame_end;

  always #2.5 clk = ~clk;

  fb_scan_addrgen i_fb_scan_addrgen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_beats(rd_beats), .rd_gnt(rd_gnt),
    .rd_done(rd_done), .frame_end(frame_end)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // register mirror
  logic [31:0] mb, mp, ml, mn, mbc, mlc;
  // reference model
  logic [31:0] qa[$];
  int          qb[$];
  bit          m_active, m_eof;
  int          mout, m_lim;
  int          exp_total, exp_bmax;
  // stimulus controls
  bit          fs_now, we_now;
  logic [2:0]  sel_now;
  logic [31:0] wd_now;
  int          gnt_pct, done_pct;
  // per-frame observations
  int          acc_cnt, eof_cnt, max_b, peak;
  logic [31:0] first_addr;
  bit          prev_wait;
  logic [31:0] prev_addr;
  logic [4:0]  prev_beats;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  function automatic int dec_burst(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic build();
    int lb, bm;
    qa.delete();
    qb.delete();
    lb = (ml + BB - 1) / BB;
    if (lb == 0) lb = 1;
    bm = dec_burst(mbc[1:0]);
    exp_bmax = 0;
    for (int l = 0; l <= int'(mn); l++) begin
      logic [31:0] a;
      int left;
      a = mb + 32'(l) * mp;
      left = lb;
      while (left > 0) begin
        int b;
        b = (left < bm) ? left : bm;
        qa.push_back(a);
        qb.push_back(b);
        if (b > exp_bmax) exp_bmax = b;
        a = a + 32'(b * BB);
        left = left - b;
      end
    end
    exp_total = qa.size();
  endtask

  task automatic step();
    bit exp_req, acc, was_active, g, d;
    exp_req = (qa.size() > 0) && (mout < m_lim);
    chk("R5", "rd_req", rd_req, exp_req);
    if (exp_req && rd_req) begin
      chk("R2", "rd_addr", rd_addr, qa[0]);
      chk("R3", "rd_beats", rd_beats, qb[0]);
    end
    chk("R9", "frame_end", frame_end, m_eof);
    if (prev_wait) begin
      chk("R6", "held rd_addr", rd_addr, prev_addr);
      chk("R6", "held rd_beats", rd_beats, prev_beats);
    end
    if (frame_end) eof_cnt++;
    g = ($urandom_range(99) < gnt_pct);
    d = (mout > 0) && ($urandom_range(99) < done_pct);
    rd_gnt      = g;
    rd_done     = d;
    frame_start = fs_now;
    cfg_we      = we_now;
    cfg_sel     = sel_now;
    cfg_wdata   = wd_now;
    if (rd_req && g) begin
      if (acc_cnt == 0) first_addr = rd_addr;
      acc_cnt++;
      if (int'(rd_beats) > max_b) max_b = int'(rd_beats);
    end
    prev_wait  = rd_req && !g;
    prev_addr  = rd_addr;
    prev_beats = rd_beats;
    acc = exp_req && g;
    was_active = m_active;
    m_eof = 1'b0;
    if (acc) begin
      void'(qa.pop_front());
      void'(qb.pop_front());
      if (qa.size() == 0) begin
        m_active = 1'b0;
        m_eof    = 1'b1;
      end
    end
    mout = mout + int'(acc) - int'(d);
    if (mout > peak) peak = mout;
    if (fs_now && !was_active) begin
      build();
      m_active = 1'b1;
      m_lim    = int'(mlc) + 1;
    end
    if (we_now) begin
      case (sel_now)
        3'd0: mb = wd_now;
        3'd1: ml = {16'h0, wd_now[15:0]};
        3'd2: mp = wd_now;
        3'd3: mn = (wd_now > 32'd4095) ? 32'd4095 : wd_now;
        3'd4: begin mbc = {30'h0, wd_now[1:0]}; mlc = {28'h0, wd_now[11:8]}; end
        default: ;
      endcase
    end
    fs_now = 1'b0;
    we_now = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [31:0] d);
    we_now  = 1'b1;
    sel_now = sel;
    wd_now  = d;
    step();
  endtask

  task automatic start_frame();
    acc_cnt = 0; eof_cnt = 0; max_b = 0; peak = 0;
    fs_now = 1'b1;
    step();
  endtask

  task automatic finish_frame(input string tag);
    int guard = 0;
    while ((m_active || mout > 0 || m_eof) && guard < 30000) begin
      step();
      guard++;
    end
    chk(tag, "accepted requests", acc_cnt, exp_total);
    chk("R9", "end-of-frame pulses", eof_cnt, 1);
    chk("R4", "largest burst", max_b, exp_bmax);
    chk("R5", "peak outstanding within limit", (peak <= m_lim), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; frame_start = 1'b0;
    rd_gnt = 1'b0; rd_done = 1'b0;
    mb = '0; mp = '0; ml = '0; mn = '0; mbc = '0; mlc = '0;
    m_active = 1'b0; m_eof = 1'b0; mout = 0; m_lim = 1;
    fs_now = 1'b0; we_now = 1'b0; sel_now = '0; wd_now = '0;
    gnt_pct = 100; done_pct = 80; prev_wait = 1'b0;
    prev_addr = '0; prev_beats = '0; first_addr = '0;
    acc_cnt = 0; eof_cnt = 0; max_b = 0; peak = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "rd_req in reset", rd_req, 0);
    chk("R1", "frame_end in reset", frame_end, 0);
    rst_n = 1'b1;
    repeat (3) step();

    // 25-beat lines, 16-beat bursts, limit 4
    cfg(3'd0, 32'h0000_1000);
    cfg(3'd1, 32'd200);
    cfg(3'd2, 32'd256);
    cfg(3'd3, 32'd3);
    cfg(3'd4, (32'd3 << 8) | 32'd3);
    gnt_pct = 100; done_pct = 80;
    start_frame();
    finish_frame("R2");

    // 4-beat bursts, single outstanding, stalled grants and slow responses
    cfg(3'd0, 32'h0002_0000);
    cfg(3'd1, 32'd70);
    cfg(3'd2, 32'h100);
    cfg(3'd3, 32'd2);
    cfg(3'd4, (32'd0 << 8) | 32'd1);
    gnt_pct = 60; done_pct = 30;
    start_frame();
    finish_frame("R5");

    // mid-frame writes and a second start during the frame
    cfg(3'd0, 32'h0000_4000);
    cfg(3'd1, 32'd130);
    cfg(3'd2, 32'h200);
    cfg(3'd3, 32'd5);
    cfg(3'd4, (32'd1 << 8) | 32'd2);
    gnt_pct = 70; done_pct = 50;
    start_frame();
    repeat (4) step();
    cfg(3'd0, 32'h0000_9000);
    cfg(3'd2, 32'h300);
    fs_now = 1'b1;
    step();
    finish_frame("R10");
    chk("R7", "first address of running frame", first_addr, 32'h0000_4000);

    // next frame picks up the new base and pitch
    start_frame();
    finish_frame("R7");
    chk("R7", "first address of next frame", first_addr, 32'h0000_9000);

    // zero length line, single-beat bursts
    cfg(3'd1, 32'd0);
    cfg(3'd3, 32'd1);
    cfg(3'd4, (32'd7 << 8) | 32'd0);
    gnt_pct = 100; done_pct = 60;
    start_frame();
    finish_frame("R3");
    chk("R3", "zero length gives one beat per line", acc_cnt, 2);

    // saturated line count
    cfg(3'd0, 32'h0);
    cfg(3'd1, 32'd8);
    cfg(3'd2, 32'd8);
    cfg(3'd3, 32'hFFFF_FFFF);
    cfg(3'd4, (32'd15 << 8) | 32'd3);
    gnt_pct = 100; done_pct = 100;
    start_frame();
    finish_frame("R8");
    chk("R8", "lines with saturated count", acc_cnt, 4096);

    repeat (4) step();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule